// File: doc/BRIEF.md
# Frame-Interval Timeout Monitor

This block watches the spacing of frame markers on a full-speed serial bus from the device side. A down counter is paced by a 12 MHz timing strobe and is refilled from a programmable interval register whenever a start-of-frame or end-of-packet marker arrives. If the count runs out before the next marker, the block raises a sticky timeout flag. It also bumps a small saturating tally of timeouts, and it can raise an interrupt.

Every start-of-frame marker carries an 11-bit frame number, and the block latches it. A single status word packs the flag, the tally and the latched frame number so that software can read them in one access. Software sets the interval a little above the spacing it expects. The interrupt is cleared by writing a one to the flag position.

Top module: `frame_watch`

## Requirements
- R1: After reset the interval register and the down counter both hold 0x2EE0 (12000), the status word is 0x0000 and the interrupt output is low.
- R2: The down counter drops by one on each cycle with the timing strobe and holds when the strobe is low. It can always be read back. Writing the interval register does not change the running count; the new value is used at the next refill.
- R3: When the strobe arrives with the count at 1 or 0 and no marker in that cycle, the timeout flag sets and the counter refills from the interval register, then keeps counting. An interval of N (N ≥ 1) therefore expires on the N-th strobe after a refill, and an interval of 0 expires on the first strobe.
- R4: Status word layout: bit 15 is the timeout flag, bits 14:12 are the timeout tally, bit 11 always reads 0, and bits 10:0 are the latched frame number.
- R5: A start-of-frame or end-of-packet pulse refills the counter from the interval register and clears the timeout flag. A pulse in the same cycle as a strobe takes priority, and no timeout occurs.
- R6: Each timeout adds one to the 3-bit tally, which stops at 7. A start-of-frame pulse clears the tally; an end-of-packet pulse leaves it unchanged.
- R7: The frame number input is captured only on a start-of-frame pulse; an end-of-packet pulse does not capture it.
- R8: The interrupt output is high exactly when the timeout flag is set and the interrupt enable input is high.
- R9: A flag write with value 1 clears the timeout flag, and a flag write with value 0 has no effect. A timeout in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 12 MHz timing strobe, one cycle wide |
| sofPulse | input | 1 | Start-of-frame marker pulse |
| eopPulse | input | 1 | End-of-packet marker pulse |
| frameIn | input | 11 | Frame number carried by the start-of-frame |
| cfgWrEn | input | 1 | Write strobe for the interval register |
| cfgWrData | input | 16 | New interval value |
| flagWrEn | input | 1 | Write strobe for the flag position of the status word |
| flagWrBit | input | 1 | Value written to the flag position (1 clears) |
| irqEnable | input | 1 | Timeout interrupt enable |
| intervalOut | output | 16 | Interval register readback |
| countOut | output | 16 | Current down-counter value |
| statusOut | output | 16 | Packed status word |
| irqOut | output | 1 | Timeout interrupt |

## Verification
The bench uses the default 16-bit counter, 11-bit frame and 3-bit tally, and checks the 12000-strobe reset interval once at full length. It then programs intervals from 0 to 8. These small values put every expiry point, the zero and one boundary and tally saturation within a few dozen cycles. They also allow a cycle-by-cycle reference model to be compared at every step. Dedicated cases cover same-cycle collisions: a marker against a strobe, and a clearing write against an expiry.

// File: rtl/frame_watch_pkg.sv
package frame_watch_pkg;

  // Strobes from the control decode to the datapath registers
  typedef struct packed {
    logic reload;      // refill the down counter from the interval register
    logic expire;      // timeout event this cycle
    logic clrFlag;     // clear the sticky timeout flag
    logic clrTally;    // clear the timeout tally
    logic latchFrame;  // capture the incoming frame number
  } fwStrobe_t;

endpackage

// File: rtl/frame_watch_ctrl.sv
module frame_watch_ctrl
  import frame_watch_pkg::*;
(
  input  logic      tickEn,
  input  logic      sofPulse,
  input  logic      eopPulse,
  input  logic      flagWrEn,
  input  logic      flagWrBit,
  input  logic      nearZero,
  output fwStrobe_t strobes
);

  logic anyMarker;

  always_comb begin
    anyMarker          = sofPulse | eopPulse;
    // a marker always wins over a strobe in the same cycle
    strobes.expire     = tickEn & ~anyMarker & nearZero;
    strobes.reload     = anyMarker | strobes.expire;
    strobes.clrFlag    = anyMarker | (flagWrEn & flagWrBit);
    strobes.clrTally   = sofPulse;
    strobes.latchFrame = sofPulse;
  end

endmodule

// File: rtl/frame_watch_dp.sv
module frame_watch_dp
  import frame_watch_pkg::*;
#(
  parameter int                  CNT_W      = 16,
  parameter int                  FRAME_W    = 11,
  parameter int                  TALLY_W    = 3,
  parameter logic [CNT_W-1:0]    RESET_IVAL = 16'h2EE0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  fwStrobe_t          strobes,
  input  logic               cfgWrEn,
  input  logic [CNT_W-1:0]   cfgWrData,
  input  logic [FRAME_W-1:0] frameIn,
  output logic [CNT_W-1:0]   intervalQ,
  output logic [CNT_W-1:0]   countQ,
  output logic               flagQ,
  output logic [TALLY_W-1:0] tallyQ,
  output logic [FRAME_W-1:0] frameQ,
  output logic               nearZero
);

  localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};
  localparam logic [CNT_W-1:0]   CNT_ONE   = CNT_W'(1);

  assign nearZero = (countQ <= CNT_ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalQ <= RESET_IVAL;
    end else if (cfgWrEn) begin
      intervalQ <= cfgWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= RESET_IVAL;
    end else if (strobes.reload) begin
      countQ <= intervalQ;
    end else if (tickEn) begin
      countQ <= countQ - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobes.expire) begin
      flagQ <= 1'b1;
    end else if (strobes.clrFlag) begin
      flagQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tallyQ <= '0;
    end else if (strobes.clrTally) begin
      tallyQ <= '0;
    end else if (strobes.expire && tallyQ != TALLY_MAX) begin
      tallyQ <= tallyQ + TALLY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameQ <= '0;
    end else if (strobes.latchFrame) begin
      frameQ <= frameIn;
    end
  end

endmodule

// File: rtl/frame_watch.sv
module frame_watch
  import frame_watch_pkg::*;
#(
  parameter int               CNT_W      = 16,
  parameter int               FRAME_W    = 11,
  parameter int               TALLY_W    = 3,
  parameter logic [CNT_W-1:0] RESET_IVAL = 16'h2EE0,
  localparam int              STAT_W     = 1 + TALLY_W + 1 + FRAME_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               sofPulse,
  input  logic               eopPulse,
  input  logic [FRAME_W-1:0] frameIn,
  input  logic               cfgWrEn,
  input  logic [CNT_W-1:0]   cfgWrData,
  input  logic               flagWrEn,
  input  logic               flagWrBit,
  input  logic               irqEnable,
  output logic [CNT_W-1:0]   intervalOut,
  output logic [CNT_W-1:0]   countOut,
  output logic [STAT_W-1:0]  statusOut,
  output logic               irqOut
);

  fwStrobe_t          strobes;
  logic               nearZero;
  logic               flagQ;
  logic [TALLY_W-1:0] tallyQ;
  logic [FRAME_W-1:0] frameQ;

  frame_watch_ctrl u_ctrl (
    .tickEn    (tickEn),
    .sofPulse  (sofPulse),
    .eopPulse  (eopPulse),
    .flagWrEn  (flagWrEn),
    .flagWrBit (flagWrBit),
    .nearZero  (nearZero),
    .strobes   (strobes)
  );

  frame_watch_dp #(
    .CNT_W      (CNT_W),
    .FRAME_W    (FRAME_W),
    .TALLY_W    (TALLY_W),
    .RESET_IVAL (RESET_IVAL)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .strobes   (strobes),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .frameIn   (frameIn),
    .intervalQ (intervalOut),
    .countQ    (countOut),
    .flagQ     (flagQ),
    .tallyQ    (tallyQ),
    .frameQ    (frameQ),
    .nearZero  (nearZero)
  );

  // flag on top, tally below it, one reserved zero, frame number at the bottom
  assign statusOut = {flagQ, tallyQ, 1'b0, frameQ};
  assign irqOut    = flagQ & irqEnable;

endmodule

// File: rtl/frame_watch_chk.sv
module frame_watch_chk #(
  parameter int CNT_W   = 16,
  parameter int FRAME_W = 11,
  parameter int TALLY_W = 3,
  localparam int STAT_W = 1 + TALLY_W + 1 + FRAME_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              sofPulse,
  input logic              eopPulse,
  input logic              flagWrEn,
  input logic              flagWrBit,
  input logic              irqEnable,
  input logic [CNT_W-1:0]  intervalOut,
  input logic [CNT_W-1:0]  countOut,
  input logic [STAT_W-1:0] statusOut,
  input logic              irqOut
);

  localparam int FLAG_POS = STAT_W - 1;
  localparam int TALLY_HI = STAT_W - 2;

  logic anyMarker;
  logic dueNow;
  assign anyMarker = sofPulse | eopPulse;
  assign dueNow    = tickEn & ~anyMarker & (countOut <= CNT_W'(1));

  // R2: counter holds with no strobe and no marker
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !anyMarker) |=> $stable(countOut));

  // R3: due strobe sets the flag and refills
  a_r3_expire_sets: assert property (@(posedge clk) disable iff (!rstN)
    dueNow |=> (statusOut[FLAG_POS] && countOut == $past(intervalOut)));

  // R5: marker refills and clears the flag
  a_r5_marker_refill: assert property (@(posedge clk) disable iff (!rstN)
    anyMarker |=> (countOut == $past(intervalOut) && !statusOut[FLAG_POS]));

  // R6: saturated tally stays at its maximum without a start-of-frame
  a_r6_tally_sat: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[TALLY_HI -: TALLY_W] == {TALLY_W{1'b1}} && !sofPulse)
      |=> statusOut[TALLY_HI -: TALLY_W] == {TALLY_W{1'b1}});

  // R7: frame field holds without a start-of-frame
  a_r7_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sofPulse |=> $stable(statusOut[FRAME_W-1:0]));

  // R8: interrupt only with flag set and enable high
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusOut[FLAG_POS] && irqEnable));

  // R9: clearing write without a coinciding timeout drops the flag
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && flagWrBit && !dueNow) |=> !statusOut[FLAG_POS]);

endmodule

bind frame_watch frame_watch_chk #(
  .CNT_W   (CNT_W),
  .FRAME_W (FRAME_W),
  .TALLY_W (TALLY_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tickEn      (tickEn),
  .sofPulse    (sofPulse),
  .eopPulse    (eopPulse),
  .flagWrEn    (flagWrEn),
  .flagWrBit   (flagWrBit),
  .irqEnable   (irqEnable),
  .intervalOut (intervalOut),
  .countOut    (countOut),
  .statusOut   (statusOut),
  .irqOut      (irqOut)
);

// File: tb/frame_watch_tb.sv
module frame_watch_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, sofPulse = 1'b0, eopPulse = 1'b0;
  logic [10:0] frameIn = '0;
  logic        cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic        flagWrEn = 1'b0, flagWrBit = 1'b0, irqEnable = 1'b0;
  logic [15:0] intervalOut, countOut, statusOut;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference state, derived from the requirements
  logic [15:0] mCnt, mIval;
  logic        mFlag;
  logic [2:0]  mTally;
  logic [10:0] mFrame;

  always #5 clk = ~clk;

  frame_watch u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sofPulse(sofPulse),
    .eopPulse(eopPulse), .frameIn(frameIn), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .flagWrEn(flagWrEn), .flagWrBit(flagWrBit),
    .irqEnable(irqEnable), .intervalOut(intervalOut), .countOut(countOut),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " count"}, 32'(countOut), 32'(mCnt));
    check({tag, " interval"}, 32'(intervalOut), 32'(mIval));
    check({tag, " status"}, 32'(statusOut), 32'({mFlag, mTally, 1'b0, mFrame}));
    check({tag, " irq"}, 32'(irqOut), 32'(mFlag & irqEnable));
  endtask

  // one clock with the given inputs; reference updated alongside
  task automatic cyc(input logic tk, input logic sf, input logic ep,
                     input logic [10:0] fr, input logic cw, input logic [15:0] cd,
                     input logic fw, input logic fb);
    logic ev, ex;
    tickEn = tk; sofPulse = sf; eopPulse = ep; frameIn = fr;
    cfgWrEn = cw; cfgWrData = cd; flagWrEn = fw; flagWrBit = fb;
    ev = sf | ep;
    ex = tk & ~ev & (mCnt <= 16'd1);
    if (ev | ex) mCnt = mIval;
    else if (tk) mCnt = mCnt - 16'd1;
    if (ex) mFlag = 1'b1;
    else if (ev | (fw & fb)) mFlag = 1'b0;
    if (sf) mTally = 3'd0;
    else if (ex && mTally != 3'd7) mTally = mTally + 3'd1;
    if (sf) mFrame = fr;
    if (cw) mIval = cd;
    @(posedge clk);
    #2;
    tickEn = 0; sofPulse = 0; eopPulse = 0; cfgWrEn = 0; flagWrEn = 0; flagWrBit = 0;
  endtask

  task automatic tick();           cyc(1, 0, 0, 11'd0, 0, 16'd0, 0, 0); endtask
  task automatic idle();           cyc(0, 0, 0, 11'd0, 0, 16'd0, 0, 0); endtask
  task automatic sof(input logic [10:0] f); cyc(0, 1, 0, f, 0, 16'd0, 0, 0); endtask
  task automatic eop(input logic [10:0] f); cyc(0, 0, 1, f, 0, 16'd0, 0, 0); endtask
  task automatic setIval(input logic [15:0] v); cyc(0, 0, 0, 11'd0, 1, v, 0, 0); endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mCnt = 16'h2EE0; mIval = 16'h2EE0; mFlag = 0; mTally = 0; mFrame = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1 reset values
    check("R1 interval", 32'(intervalOut), 32'h2EE0);
    check("R1 count", 32'(countOut), 32'h2EE0);
    check("R1 status", 32'(statusOut), 32'h0);
    check("R1 irq", 32'(irqOut), 32'h0);

    // R3 default interval: expiry on strobe 12000
    irqEnable = 1'b1;
    sof(11'h123);
    for (int i = 0; i < 11999; i++) tick();
    check("R3 default no flag yet", 32'(statusOut[15]), 32'h0);
    check("R2 default count at 1", 32'(countOut), 32'h1);
    tick();
    check("R3 default flag", 32'(statusOut[15]), 32'h1);
    check("R3 default refill", 32'(countOut), 32'h2EE0);
    check("R8 irq enabled", 32'(irqOut), 32'h1);
    checkAll("R4 default");

    // R3/R8 sweep intervals 1..8, enable alternating
    for (int n = 1; n <= 8; n++) begin
      irqEnable = n[0];
      setIval(16'(n));
      sof(11'(n * 37));
      for (int k = 1; k < n; k++) tick();
      check("R3 sweep before expiry", 32'(statusOut[15]), 32'h0);
      check("R2 sweep count", 32'(countOut), 32'h1);
      tick();
      check("R3 sweep flag", 32'(statusOut[15]), 32'h1);
      check("R3 sweep refill", 32'(countOut), 32'(n));
      check("R8 sweep irq", 32'(irqOut), 32'(n % 2));
      checkAll("R4 sweep");
    end

    // R3 interval 0 expires on every strobe
    irqEnable = 1'b1;
    setIval(16'd0);
    sof(11'h7FF);
    check("R3 zero refill", 32'(countOut), 32'h0);
    tick();
    check("R3 zero flag", 32'(statusOut[15]), 32'h1);
    check("R6 zero tally", 32'(statusOut[14:12]), 32'h1);

    // R6 saturation: interval 2, ten expiries
    setIval(16'd2);
    sof(11'h055);
    for (int e = 1; e <= 10; e++) begin
      tick(); tick();
      check("R6 tally", 32'(statusOut[14:12]), 32'((e > 7) ? 7 : e));
    end
    // R5/R6/R7 end-of-packet clears flag, keeps tally and frame
    eop(11'h3AA);
    check("R5 eop clears flag", 32'(statusOut[15]), 32'h0);
    check("R6 eop keeps tally", 32'(statusOut[14:12]), 32'h7);
    check("R7 eop no capture", 32'(statusOut[10:0]), 32'h055);
    check("R5 eop refill", 32'(countOut), 32'h2);
    sof(11'h2C1);
    check("R6 sof clears tally", 32'(statusOut[14:12]), 32'h0);
    check("R7 sof capture", 32'(statusOut[10:0]), 32'h2C1);
    checkAll("R4 after sof");

    // R5 marker in same cycle as a due strobe
    tick();
    check("R2 count 1", 32'(countOut), 32'h1);
    cyc(1, 0, 1, 11'd0, 0, 16'd0, 0, 0);
    check("R5 marker wins", 32'(statusOut[15]), 32'h0);
    check("R5 marker refill", 32'(countOut), 32'h2);

    // R9 write-one-to-clear
    setIval(16'd1);
    sof(11'h001);
    tick();
    check("R9 flag set", 32'(statusOut[15]), 32'h1);
    cyc(0, 0, 0, 11'd0, 0, 16'd0, 1, 0);
    check("R9 write zero ignored", 32'(statusOut[15]), 32'h1);
    cyc(0, 0, 0, 11'd0, 0, 16'd0, 1, 1);
    check("R9 write one clears", 32'(statusOut[15]), 32'h0);
    check("R8 irq drops", 32'(irqOut), 32'h0);
    cyc(1, 0, 0, 11'd0, 0, 16'd0, 1, 1);
    check("R9 expiry beats clear", 32'(statusOut[15]), 32'h1);
    checkAll("R9 collision");

    // R2 interval write does not disturb running count; hold without strobe
    setIval(16'd10);
    sof(11'h010);
    for (int i = 0; i < 3; i++) tick();
    setIval(16'd100);
    check("R2 count unchanged by write", 32'(countOut), 32'h7);
    for (int i = 0; i < 5; i++) idle();
    check("R2 hold without strobe", 32'(countOut), 32'h7);
    for (int i = 0; i < 7; i++) tick();
    check("R2 new interval at refill", 32'(countOut), 32'd100);
    check("R3 expiry after write", 32'(statusOut[15]), 32'h1);
    checkAll("R2 final");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule